// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the digital drive pattern for a two-phase full-frame CCD area sensor. A start request opens an exposure window. During that window both vertical clock phases are held low for a length given on an input port. The block then reads out a frame of `LINES` rows. Each row begins with a three-interval vertical transfer that moves one row into the horizontal register. A settling gap follows. The horizontal phases are then driven in complementary fashion for every element of the register, and one extra trailing pixel period closes the row.

A reset-gate clock pulses at the start of every pixel period. It keeps running from a free-running phase counter when no row is being shifted, and that counter is realigned when horizontal shifting begins. A pixel-valid strobe marks the cycle after each packet is dumped onto the sense node, so a downstream converter knows when to sample. All durations are counts of the system clock and are set by parameters. An elaboration-time check rejects durations shorter than the sensor minimums for the stated clock frequency. Level shifting, clock drivers and the analog chain lie outside this block.

Top module: `ccd_frame_sequencer`

## Requirements
- R1: While reset is asserted, the block drives v1_o, v2_o, h2_o, r_o, busy_o, line_start_o, pix_valid_o and frame_done_o low and h1_o high.
- R2: A frame has exactly LINES rows. line_start_o is high for one cycle at the first cycle of each row. Rows follow each other with no gap, and each row lasts 3·TV_CYC + THS_CYC + (HPIX+1)·TPIX_CYC cycles.
- R3: The vertical transfer is three TV_CYC intervals: v1_o high, then v2_o high, then both low. h1_o stays high and h2_o stays low throughout, so v2_o falls while h1_o is high.
- R4: After the vertical transfer, h1_o stays high and h2_o stays low for THS_CYC cycles before h2_o first rises.
- R5: Horizontal shifting lasts HPIX pixel periods of TPIX_CYC cycles. In each period h2_o is high for the first TPIX_CYC/2 cycles and h1_o is its complement. One further period with h1_o high and h2_o low ends the row.
- R6: r_o is high for the first TR_CYC cycles of every horizontal pixel period and of the trailing period. Outside rows it keeps pulsing, TR_CYC cycles high in every TPIX_CYC cycles.
- R7: pix_valid_o is high for one cycle, one cycle after each falling edge of h2_o. This gives exactly HPIX strobes per row.
- R8: A start request accepted while idle latches int_len_i as N. busy_o then goes high with v1_o and v2_o low for max(N,1) cycles before the first line_start_o. Later changes to int_len_i do not affect that frame.
- R9: frame_done_o is high for one cycle, the first cycle in which busy_o is low after the last row. A start request while busy_o is high is ignored. A start held high through frame completion begins a new exposure, with busy_o high again the next cycle.
- R10: Elaboration rejects TV_CYC, THS_CYC, TPIX_CYC or TR_CYC below the sensor minimums for CLK_MHZ (1.5 µs, 0.5 µs, 100 ns, 10 ns). It also rejects an odd TPIX_CYC or one below 4, and a TR_CYC that is not below TPIX_CYC/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Exposure start request |
| int_len_i | input | INT_W | Exposure length in clock cycles |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| r_o | output | 1 | Reset-gate clock |
| busy_o | output | 1 | Exposure or readout in progress |
| line_start_o | output | 1 | First cycle of each row |
| pix_valid_o | output | 1 | Sample strobe after each packet dump |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two events can land in the same cycle: frame completion, and a start request arriving in the first idle cycle. The bench holds start_i high from before a frame is accepted until that frame ends. It checks that the request is ignored in every row, so the row count and the per-cycle clock pattern stay unchanged. It then checks that frame_done_o appears for exactly one cycle with busy_o low, and that busy_o rises again on the very next cycle. The exposure length measured for the new frame must match the value presented in that final row, not a value latched earlier.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_EXPOSE,
    SQ_VXFER,
    SQ_SETUP,
    SQ_HSHIFT,
    SQ_TAIL
  } seq_state_t;

  typedef struct packed {
    logic v1;
    logic v2;
    logic h1;
    logic h2;
    logic r;
    logic busy;
    logic line_start;
    logic frame_done;
  } drive_t;

  localparam drive_t DRV_RESET = '{v1: 1'b0, v2: 1'b0, h1: 1'b1, h2: 1'b0,
                                   r: 1'b0, busy: 1'b0, line_start: 1'b0,
                                   frame_done: 1'b0};

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ccd_seq_pixclk.sv
module ccd_seq_pixclk #(
  parameter int unsigned TPIX_CYC = 26,
  parameter int unsigned TR_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic ph_last_o,
  output logic hi_half_o,
  output logic r_o
);

  localparam int unsigned PH_W = $clog2(TPIX_CYC);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_last_o = (ph_q == PH_W'(TPIX_CYC - 1));
    hi_half_o = (ph_q < PH_W'(TPIX_CYC / 2));
    r_o       = (ph_q < PH_W'(TR_CYC));
    if (restart_i || ph_last_o) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  // A realigned period must open with the reset-gate pulse.
  assert_restart_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> r_o);

  // The phase never leaves its modulus.
  assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_last_o |=> (ph_q == '0));

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int unsigned LINES   = 520,
  parameter int unsigned HPIX    = 796,
  parameter int unsigned TV_CYC  = 200,
  parameter int unsigned THS_CYC = 100,
  parameter int unsigned INT_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_len_i,
  input  logic             ph_last_i,
  output seq_state_t       state_o,
  output logic [1:0]       seg_o,
  output logic             restart_o,
  output logic             line_first_o,
  output logic             done_o
);

  localparam int unsigned DUR_W  = max2(INT_W, max2($clog2(TV_CYC + 1), $clog2(THS_CYC + 1)));
  localparam int unsigned PIX_W  = $clog2(HPIX + 1);
  localparam int unsigned LINE_W = $clog2(LINES + 1);
  localparam logic [DUR_W-1:0]  TV_LD   = DUR_W'(TV_CYC - 1);
  localparam logic [DUR_W-1:0]  THS_LD  = DUR_W'(THS_CYC - 1);
  localparam logic [PIX_W-1:0]  PIX_END = PIX_W'(HPIX - 1);
  localparam logic [LINE_W-1:0] LN_END  = LINE_W'(LINES - 1);

  seq_state_t        state_q, state_d;
  logic [DUR_W-1:0]  dur_q, dur_d;
  logic [1:0]        seg_q, seg_d;
  logic [PIX_W-1:0]  pix_q, pix_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              first_q, first_d;
  logic              done_q, done_d;
  logic              dur_zero;

  assign dur_zero = (dur_q == '0);

  always_comb begin
    state_d   = state_q;
    dur_d     = dur_q;
    seg_d     = seg_q;
    pix_d     = pix_q;
    line_d    = line_q;
    first_d   = 1'b0;
    done_d    = 1'b0;
    restart_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          state_d = SQ_EXPOSE;
          line_d  = '0;
          dur_d   = (int_len_i == '0) ? '0 : DUR_W'(int_len_i - INT_W'(1));
        end
      end
      SQ_EXPOSE: begin
        if (dur_zero) begin
          state_d = SQ_VXFER;
          seg_d   = 2'd0;
          dur_d   = TV_LD;
          first_d = 1'b1;
        end else begin
          dur_d = dur_q - 1'b1;
        end
      end
      SQ_VXFER: begin
        if (dur_zero) begin
          if (seg_q == 2'd2) begin
            state_d = SQ_SETUP;
            dur_d   = THS_LD;
          end else begin
            seg_d = seg_q + 1'b1;
            dur_d = TV_LD;
          end
        end else begin
          dur_d = dur_q - 1'b1;
        end
      end
      SQ_SETUP: begin
        if (dur_zero) begin
          state_d   = SQ_HSHIFT;
          pix_d     = '0;
          restart_o = 1'b1;
        end else begin
          dur_d = dur_q - 1'b1;
        end
      end
      SQ_HSHIFT: begin
        if (ph_last_i) begin
          if (pix_q == PIX_END) begin
            state_d = SQ_TAIL;
          end else begin
            pix_d = pix_q + 1'b1;
          end
        end
      end
      SQ_TAIL: begin
        if (ph_last_i) begin
          if (line_q == LN_END) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
          end else begin
            line_d  = line_q + 1'b1;
            state_d = SQ_VXFER;
            seg_d   = 2'd0;
            dur_d   = TV_LD;
            first_d = 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      dur_q   <= '0;
      seg_q   <= '0;
      pix_q   <= '0;
      line_q  <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dur_q   <= dur_d;
      seg_q   <= seg_d;
      pix_q   <= pix_d;
      line_q  <= line_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  assign state_o      = state_q;
  assign seg_o        = seg_q;
  assign line_first_o = first_q;
  assign done_o       = done_q;

  // Row index stays inside the frame.
  assert_line_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LN_END);

  // Vertical transfer uses only three intervals.
  assert_seg_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_VXFER) |-> (seg_q <= 2'd2));

  // Exposure only ever hands over to the first vertical transfer.
  assert_expose_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_EXPOSE) |=> (state_q == SQ_EXPOSE || state_q == SQ_VXFER));

  // Pixel count stays inside the horizontal register.
  assert_pix_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_q <= PIX_END);

endmodule

// File: rtl/ccd_seq_outreg.sv
module ccd_seq_outreg
  import ccd_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  drive_t drv_i,
  output drive_t drv_o,
  output logic   pix_valid_o
);

  drive_t drv_q;
  logic   h2_prev_q;
  logic   pv_q;
  logic   pv_d;

  assign pv_d = h2_prev_q & ~drv_q.h2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q     <= DRV_RESET;
      h2_prev_q <= 1'b0;
      pv_q      <= 1'b0;
    end else begin
      drv_q     <= drv_i;
      h2_prev_q <= drv_q.h2;
      pv_q      <= pv_d;
    end
  end

  assign drv_o       = drv_q;
  assign pix_valid_o = pv_q;

  // Strobe follows a falling horizontal phase 2 by one cycle.
  assert_pix_valid_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> ($past(drv_q.h2, 2) && !$past(drv_q.h2, 1)));

endmodule

// File: rtl/ccd_frame_sequencer.sv
module ccd_frame_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned LINES    = 520,
  parameter int unsigned HPIX     = 796,
  parameter int unsigned TV_CYC   = 200,
  parameter int unsigned THS_CYC  = 100,
  parameter int unsigned TPIX_CYC = 26,
  parameter int unsigned TR_CYC   = 2,
  parameter int unsigned INT_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_len_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             r_o,
  output logic             busy_o,
  output logic             line_start_o,
  output logic             pix_valid_o,
  output logic             frame_done_o
);

  localparam int unsigned TV_MIN   = (3 * CLK_MHZ + 1) / 2;
  localparam int unsigned THS_MIN  = (CLK_MHZ + 1) / 2;
  localparam int unsigned TPIX_MIN = (CLK_MHZ + 9) / 10;
  localparam int unsigned TR_MIN   = (CLK_MHZ + 99) / 100;

  initial begin
    assert_tv_min_R10: assert (TV_CYC >= TV_MIN)
      else $error("vertical pulse width below minimum");
    assert_ths_min_R10: assert (THS_CYC >= THS_MIN)
      else $error("horizontal setup below minimum");
    assert_tpix_min_R10: assert (TPIX_CYC >= TPIX_MIN && TPIX_CYC >= 4 && (TPIX_CYC % 2) == 0)
      else $error("pixel period below minimum or odd");
    assert_tr_min_R10: assert (TR_CYC >= TR_MIN && TR_CYC < TPIX_CYC / 2)
      else $error("reset pulse width out of range");
  end

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  seq_state_t state;
  logic [1:0] seg;
  logic       restart;
  logic       line_first;
  logic       done;
  logic       ph_last;
  logic       hi_half;
  logic       r_raw;
  drive_t     drv_nxt;
  drive_t     drv_out;

  ccd_seq_ctrl #(
    .LINES   (LINES),
    .HPIX    (HPIX),
    .TV_CYC  (TV_CYC),
    .THS_CYC (THS_CYC),
    .INT_W   (INT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .int_len_i    (int_len_i),
    .ph_last_i    (ph_last),
    .state_o      (state),
    .seg_o        (seg),
    .restart_o    (restart),
    .line_first_o (line_first),
    .done_o       (done)
  );

  ccd_seq_pixclk #(
    .TPIX_CYC (TPIX_CYC),
    .TR_CYC   (TR_CYC)
  ) u_pixclk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart_i (restart),
    .ph_last_o (ph_last),
    .hi_half_o (hi_half),
    .r_o       (r_raw)
  );

  always_comb begin
    drv_nxt.v1         = (state == SQ_VXFER) && (seg == 2'd0);
    drv_nxt.v2         = (state == SQ_VXFER) && (seg == 2'd1);
    drv_nxt.h2         = (state == SQ_HSHIFT) && hi_half;
    drv_nxt.h1         = !drv_nxt.h2;
    drv_nxt.r          = r_raw;
    drv_nxt.busy       = (state != SQ_IDLE);
    drv_nxt.line_start = line_first;
    drv_nxt.frame_done = done;
  end

  ccd_seq_outreg u_outreg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .drv_i       (drv_nxt),
    .drv_o       (drv_out),
    .pix_valid_o (pix_valid_o)
  );

  assign v1_o         = drv_out.v1;
  assign v2_o         = drv_out.v2;
  assign h1_o         = drv_out.h1;
  assign h2_o         = drv_out.h2;
  assign r_o          = drv_out.r;
  assign busy_o       = drv_out.busy;
  assign line_start_o = drv_out.line_start;
  assign frame_done_o = drv_out.frame_done;

  // The row dump edge of phase 2 happens with phase 1 high.
  assert_v2_fall_h1_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(v2_o) |-> h1_o);

  // Frame-done is a single-cycle pulse.
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_done_o |=> !frame_done_o);

  // Frame-done only while idle.
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_done_o |-> !busy_o);

  // A row opens inside a busy frame with phase 1 raised.
  assert_line_start_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    line_start_o |-> (busy_o && v1_o && !v2_o));

endmodule

// File: tb/test_ccd_frame_sequencer.sv
module test_ccd_frame_sequencer;

  localparam int CLK_MHZ  = 4;
  localparam int LINES    = 3;
  localparam int HPIX     = 6;
  localparam int TV_CYC   = 6;
  localparam int THS_CYC  = 2;
  localparam int TPIX_CYC = 4;
  localparam int TR_CYC   = 1;
  localparam int INT_W    = 8;
  localparam int HS       = 3 * TV_CYC + THS_CYC;
  localparam int HE       = HS + HPIX * TPIX_CYC;
  localparam int LLEN     = HE + TPIX_CYC;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [INT_W-1:0] int_len_i = '0;
  logic v1_o, v2_o, h1_o, h2_o, r_o, busy_o, line_start_o, pix_valid_o, frame_done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ccd_frame_sequencer #(
    .CLK_MHZ (CLK_MHZ), .LINES (LINES), .HPIX (HPIX), .TV_CYC (TV_CYC),
    .THS_CYC (THS_CYC), .TPIX_CYC (TPIX_CYC), .TR_CYC (TR_CYC), .INT_W (INT_W)
  ) i_ccd_frame_sequencer (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .int_len_i (int_len_i),
    .v1_o (v1_o), .v2_o (v2_o), .h1_o (h1_o), .h2_o (h2_o), .r_o (r_o),
    .busy_o (busy_o), .line_start_o (line_start_o), .pix_valid_o (pix_valid_o),
    .frame_done_o (frame_done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected {v1,v2,h1,h2} at a row offset.
  function automatic logic [3:0] exp_vh(input int o);
    logic h2;
    if (o < TV_CYC) return 4'b1010;
    if (o < 2 * TV_CYC) return 4'b0110;
    if (o < HS) return 4'b0010;
    if (o < HE) begin
      h2 = ((o - HS) % TPIX_CYC) < TPIX_CYC / 2;
      return {2'b00, !h2, h2};
    end
    return 4'b0010;
  endfunction

  function automatic logic exp_r(input int o);
    return ((o - HS) % TPIX_CYC) < TR_CYC;
  endfunction

  function automatic logic exp_pv(input int o);
    int p;
    p = o - 1;
    if (p < HS || p >= HE) return 1'b0;
    return ((p - HS) % TPIX_CYC) == TPIX_CYC / 2;
  endfunction

  task automatic idle_window(input string tag);
    int hi = 0;
    for (int k = 0; k < 5 * TPIX_CYC; k++) begin
      @(negedge clk);
      hi += int'(r_o);
      chk({tag, " R6 idle v1"}, int'(v1_o), 0);
      chk({tag, " R6 idle busy"}, int'(busy_o), 0);
    end
    chk({tag, " R6 free-running reset pulse count"}, hi, 5 * TR_CYC);
  endtask

  // Entered at the sample after the edge that accepted a start.
  task automatic frame_body(input int n, input int next_len, input bit poke, input bit hold);
    int cnt = 0;
    int pv_cnt;
    int poke_line;
    int poke_off;
    poke_line = int'($urandom_range(LINES - 1, 0));
    poke_off  = int'($urandom_range(LLEN - 2, 1));
    int_len_i = INT_W'($urandom_range(255, 60));
    @(negedge clk);
    while (!line_start_o && cnt < 400) begin
      chk("R8 exposure busy", int'(busy_o), 1);
      chk("R8 exposure v1/v2 low", int'({v1_o, v2_o}), 0);
      cnt++;
      @(negedge clk);
    end
    chk("R8 exposure length", cnt, (n == 0) ? 1 : n);
    for (int ln = 0; ln < LINES; ln++) begin
      pv_cnt = 0;
      if (ln == LINES - 1) int_len_i = INT_W'(next_len);
      for (int o = 0; o < LLEN; o++) begin
        chk("R2 line_start", int'(line_start_o), int'(o == 0));
        chk("R9 busy in row", int'(busy_o), 1);
        chk("R9 no frame_done in row", int'(frame_done_o), 0);
        chk("R3/R4/R5 clock pattern", int'({v1_o, v2_o, h1_o, h2_o}), int'(exp_vh(o)));
        if (o >= HS) chk("R6 reset pulse in row", int'(r_o), int'(exp_r(o)));
        chk("R7 pixel valid", int'(pix_valid_o), int'(exp_pv(o)));
        pv_cnt += int'(pix_valid_o);
        if (poke && !hold && ln == poke_line && o == poke_off) start_i = 1'b1;
        else if (!hold) start_i = 1'b0;
        @(negedge clk);
      end
      chk("R7 strobes per row", pv_cnt, HPIX);
    end
    chk("R9 frame_done at end", int'(frame_done_o), 1);
    chk("R9 busy low at end", int'(busy_o), 0);
    chk("R7 no strobe at end", int'(pix_valid_o), 0);
    if (hold) begin
      start_i = 1'b0;
    end else begin
      @(negedge clk);
      chk("R9 frame_done single cycle", int'(frame_done_o), 0);
      chk("R9 stays idle", int'(busy_o), 0);
    end
  endtask

  task automatic launch(input int n, input bit poke);
    @(negedge clk);
    int_len_i = INT_W'(n);
    start_i   = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 busy lags request", int'(busy_o), 0);
    frame_body(n, 0, poke, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n1;
    int n2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset v1", int'(v1_o), 0);
    chk("R1 reset v2", int'(v2_o), 0);
    chk("R1 reset h1", int'(h1_o), 1);
    chk("R1 reset h2", int'(h2_o), 0);
    chk("R1 reset r", int'(r_o), 0);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset line_start", int'(line_start_o), 0);
    chk("R1 reset pix_valid", int'(pix_valid_o), 0);
    chk("R1 reset frame_done", int'(frame_done_o), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    idle_window("post-reset");
    launch(5, 1'b0);
    launch(0, 1'b0);
    launch(1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      launch(int'($urandom_range(20, 0)), 1'b1);
      repeat (int'($urandom_range(7, 0))) @(negedge clk);
    end
    idle_window("between");
    // start held across completion: ignored while busy, re-accepted at the end
    n1 = 9;
    n2 = int'($urandom_range(15, 2));
    @(negedge clk);
    int_len_i = INT_W'(n1);
    start_i   = 1'b1;
    @(negedge clk);
    frame_body(n1, n2, 1'b0, 1'b1);
    frame_body(n2, 0, 1'b0, 1'b0);
    idle_window("final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule